// File: doc/BRIEF.md
# Multi-Pass Clock Page Replacement Engine

This block chooses which physical frame to give up when a page fault occurs. Each frame has a recently-used bit, a dirty bit and a small age counter. A hand moves round the frames, looking at one frame per clock cycle. A frame is released only after the hand has passed it several times while it stayed unused. The number of passes is set at run time. A larger value follows least-recently-used order more closely, but a search can then take longer.

A modified (dirty) frame is allowed one more pass than a clean one. While a dirty frame is still waiting out that extra pass, the block asks for the frame to be written back, so the copy is often finished before the frame would be chosen. Only one writeback is outstanding at a time. A dirty frame is never chosen as victim before its writeback has been acknowledged. Memory references come in on a side port and mark frames as recently used. Fault requests start a search, and the result returns as a one-cycle done pulse that carries the victim's frame number.

Top module: `nclk_engine`

## Requirements
- R1: After reset every frame has its used bit, dirty bit and age at zero, the hand points at frame 0, and `fault_done` and `wb_req` are low.
- R2: A reference sets the frame's used bit and clears its age. If `ref_write` is high, it also sets the frame's dirty bit.
- R3: During a search the hand looks at exactly one frame per cycle and then moves to the next frame, wrapping from the last frame to frame 0. A frame with the used bit set has its used bit and age cleared and is passed over.
- R4: A frame with the used bit clear has its age increased by one. The age saturates at 2^CW-1 and never wraps to zero.
- R5: A clean frame becomes the victim when its increased age reaches `clean_lim`. `fault_done` is then high for exactly one cycle with `victim` set to that frame. The frame's bits are cleared and the hand moves past it.
- R6: When the increased age of a dirty frame reaches `clean_lim` and no writeback is outstanding, `wb_req` rises with `wb_frame` set to that frame. Both stay unchanged until the cycle in which `wb_ack` is high, and `wb_req` is low in the cycle after that.
- R7: A dirty frame is never returned as victim. Its limit is `clean_lim`+1, and once its age reaches that limit the hand skips it until its writeback has been acknowledged.
- R8: An acknowledged writeback clears the frame's dirty bit, and the clean limit then applies to the frame. If the frame was written while the writeback was outstanding, it stays dirty.
- R9: When a reference targets the frame under the hand in the same cycle, the reference wins. The frame is marked used, and the sweep neither ages it nor selects it.
- R10: A `fault_req` that arrives while a search is in progress is ignored. The search produces exactly one `fault_done`.
- R11: Starting from reset with only read references, the victim is the lowest-numbered frame that was not referenced, or frame 0 if every frame was referenced. The number of frames examined is (clean_lim-1)*NFRAMES + p + 1, where p is the victim's number. A further NFRAMES is added when every frame was referenced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clean_lim | input | CW | Passes a clean frame needs before replacement (1 to 2^CW-2) |
| ref_valid | input | 1 | A frame is referenced this cycle |
| ref_frame | input | FW | Number of the referenced frame |
| ref_write | input | 1 | The reference modifies the frame |
| fault_req | input | 1 | Start a victim search (sampled while idle) |
| fault_done | output | 1 | One-cycle pulse: a victim has been chosen |
| victim | output | FW | Chosen frame, valid while `fault_done` is high |
| wb_req | output | 1 | A writeback of `wb_frame` is wanted |
| wb_frame | output | FW | Frame to be written back |
| wb_ack | input | 1 | The writeback has finished |

## Verification
The sweep and a reference can land on the same frame in the same cycle. The bench provokes this by driving a reference to frame 0 in exactly the cycle the hand reaches frame 0 on its second pass, when that frame would otherwise be chosen. It expects frame 1 as the victim one cycle later. An acknowledge that coincides with a write to the frame being written back is checked the same way: the frame must later trigger a new writeback, not become a victim. Exhaustive sweeps over every reference pattern of a four-frame engine compare the victim and the search length against the closed-form count.

// File: rtl/nclk_pkg.sv
package nclk_pkg;

    typedef enum logic {
        PH_IDLE,
        PH_SEARCH
    } phase_e;

endpackage

// File: rtl/nclk_frame_eval.sv
module nclk_frame_eval #(
    parameter int CW = 2
) (
    input  logic          ubit,
    input  logic          dirty,
    input  logic [CW-1:0] age,
    input  logic [CW-1:0] clean_lim,
    input  logic          wb_busy,
    output logic          nxt_ubit,
    output logic [CW-1:0] nxt_age,
    output logic          take,
    output logic          start_wb
);
    localparam logic [CW-1:0] AGE_MAX = {CW{1'b1}};

    logic [CW-1:0] aged;
    logic          at_clean;
    logic          at_dirty;

    always_comb begin
        aged     = (age == AGE_MAX) ? age : age + CW'(1);
        at_clean = ({1'b0, aged} >= {1'b0, clean_lim});
        at_dirty = ({1'b0, aged} >= ({1'b0, clean_lim} + (CW+1)'(1)));
        nxt_ubit = 1'b0;
        nxt_age  = '0;
        take     = 1'b0;
        start_wb = 1'b0;
        if (!ubit) begin
            nxt_age = aged;
            if (!dirty) begin
                take = at_clean;
                if (at_clean) nxt_age = '0;
            end else begin
                // extra pass for dirty frames; copy-out starts at the clean limit
                start_wb = at_clean && !at_dirty && !wb_busy
                         || at_dirty && !wb_busy;
            end
        end
    end

endmodule

// File: rtl/nclk_engine.sv
module nclk_engine
    import nclk_pkg::*;
#(
    parameter  int NFRAMES = 16,
    parameter  int CW      = 2,
    localparam int FW      = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] clean_lim,
    input  logic          ref_valid,
    input  logic [FW-1:0] ref_frame,
    input  logic          ref_write,
    input  logic          fault_req,
    output logic          fault_done,
    output logic [FW-1:0] victim,
    output logic          wb_req,
    output logic [FW-1:0] wb_frame,
    input  logic          wb_ack
);
    localparam logic [FW-1:0] LAST = FW'(NFRAMES - 1);

    typedef struct packed {
        logic [NFRAMES-1:0]         ubit;
        logic [NFRAMES-1:0]         dirty;
        logic [NFRAMES-1:0][CW-1:0] age;
        logic [FW-1:0]              hand;
        phase_e                     phase;
        logic                       done;
        logic [FW-1:0]              victim;
        logic                       wb_busy;
        logic [FW-1:0]              wb_frame;
        logic                       wb_stale;
    } state_t;

    state_t st_q, st_d;

    logic          ev_ubit;
    logic [CW-1:0] ev_age;
    logic          ev_take;
    logic          ev_start;
    logic          collide;

    nclk_frame_eval #(.CW(CW)) eval_i (
        .ubit      (st_q.ubit[st_q.hand]),
        .dirty     (st_q.dirty[st_q.hand]),
        .age       (st_q.age[st_q.hand]),
        .clean_lim (clean_lim),
        .wb_busy   (st_q.wb_busy),
        .nxt_ubit  (ev_ubit),
        .nxt_age   (ev_age),
        .take      (ev_take),
        .start_wb  (ev_start)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        collide   = (st_q.phase == PH_SEARCH) && ref_valid && (ref_frame == st_q.hand);

        // sweep step: one frame per cycle
        if (st_q.phase == PH_SEARCH) begin
            st_d.hand = (st_q.hand == LAST) ? '0 : st_q.hand + FW'(1);
            if (!collide) begin
                st_d.ubit[st_q.hand] = ev_ubit;
                st_d.age[st_q.hand]  = ev_age;
                if (ev_take) begin
                    st_d.dirty[st_q.hand] = 1'b0;
                    st_d.done             = 1'b1;
                    st_d.victim           = st_q.hand;
                    st_d.phase            = PH_IDLE;
                end
                if (ev_start) begin
                    st_d.wb_busy  = 1'b1;
                    st_d.wb_frame = st_q.hand;
                    st_d.wb_stale = 1'b0;
                end
            end
        end else if (fault_req) begin
            st_d.phase = PH_SEARCH;
        end

        // writeback completion
        if (st_q.wb_busy) begin
            if (ref_valid && ref_write && (ref_frame == st_q.wb_frame))
                st_d.wb_stale = 1'b1;
            if (wb_ack) begin
                st_d.wb_busy = 1'b0;
                if (!st_q.wb_stale) st_d.dirty[st_q.wb_frame] = 1'b0;
            end
        end

        // references override everything else on their frame
        if (ref_valid) begin
            st_d.ubit[ref_frame] = 1'b1;
            st_d.age[ref_frame]  = '0;
            if (ref_write) st_d.dirty[ref_frame] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.ubit     <= '0;
            st_q.dirty    <= '0;
            st_q.age      <= '0;
            st_q.hand     <= '0;
            st_q.phase    <= PH_IDLE;
            st_q.done     <= 1'b0;
            st_q.victim   <= '0;
            st_q.wb_busy  <= 1'b0;
            st_q.wb_frame <= '0;
            st_q.wb_stale <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fault_done = st_q.done;
    assign victim     = st_q.victim;
    assign wb_req     = st_q.wb_busy;
    assign wb_frame   = st_q.wb_frame;

endmodule

// File: rtl/nclk_engine_chk.sv
module nclk_engine_chk #(
    parameter  int NFRAMES = 16,
    parameter  int CW      = 2,
    localparam int FW      = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       ref_valid,
    input logic [FW-1:0]              ref_frame,
    input logic                       fault_done,
    input logic [FW-1:0]              victim,
    input logic                       wb_req,
    input logic [FW-1:0]              wb_frame,
    input logic                       wb_ack,
    input logic [NFRAMES-1:0]         ubit,
    input logic [NFRAMES-1:0][CW-1:0] age
);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fault_done |=> !fault_done);

    assert_wb_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_frame)));

    assert_victim_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_done && wb_req) |-> (victim != wb_frame));

    assert_ref_marks_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |=> (ubit[$past(ref_frame)] && (age[$past(ref_frame)] == '0)));

    for (genvar i = 0; i < NFRAMES; i++) begin : g_age
        assert_age_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (age[i] != $past(age[i])) |-> ((age[i] == '0) || (age[i] == $past(age[i]) + CW'(1))));
    end

endmodule

bind nclk_engine nclk_engine_chk #(.NFRAMES(NFRAMES), .CW(CW)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ref_valid  (ref_valid),
    .ref_frame  (ref_frame),
    .fault_done (fault_done),
    .victim     (victim),
    .wb_req     (wb_req),
    .wb_frame   (wb_frame),
    .wb_ack     (wb_ack),
    .ubit       (st_q.ubit),
    .age        (st_q.age)
);

// File: tb/nclk_engine_tb.sv
module nclk_engine_tb_top;
    localparam int NF = 4;
    localparam int CW = 2;
    localparam int FW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] clean_lim = CW'(1);
    logic          ref_valid = 1'b0;
    logic [FW-1:0] ref_frame = '0;
    logic          ref_write = 1'b0;
    logic          fault_req = 1'b0;
    logic          fault_done;
    logic [FW-1:0] victim;
    logic          wb_req;
    logic [FW-1:0] wb_frame;
    logic          wb_ack = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    nclk_engine #(.NFRAMES(NF), .CW(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .clean_lim(clean_lim),
        .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
        .fault_req(fault_req), .fault_done(fault_done), .victim(victim),
        .wb_req(wb_req), .wb_frame(wb_frame), .wb_ack(wb_ack)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input int lim);
        ref_valid = 1'b0; ref_write = 1'b0; fault_req = 1'b0; wb_ack = 1'b0;
        clean_lim = CW'(lim);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic touch(input int f, input bit w);
        ref_valid = 1'b1; ref_frame = FW'(f); ref_write = w;
        @(negedge clk);
        ref_valid = 1'b0; ref_write = 1'b0;
    endtask

    task automatic ack_wb();
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
    endtask

    // examined frames = negedges until done minus one
    task automatic run_fault(input int exp_v, input int exp_e, input string tag);
        int n;
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        n = 1;
        while (!fault_done && n < 100) begin
            @(negedge clk);
            n++;
        end
        check(fault_done === 1'b1 && int'(victim) == exp_v, {tag, " victim"}, int'(victim), exp_v);
        check(n - 1 == exp_e, {tag, " frames examined"}, n - 1, exp_e);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_reset(1);
        // R1: outputs quiet after reset
        check(fault_done == 1'b0, "R1 fault_done after reset", int'(fault_done), 0);
        check(wb_req == 1'b0, "R1 wb_req after reset", int'(wb_req), 0);

        // R11 / R3 / R5: every read pattern, both clean limits
        for (int lim = 1; lim <= 2; lim++) begin
            for (int m = 0; m < 16; m++) begin
                int p;
                int e;
                do_reset(lim);
                for (int f = 0; f < NF; f++) if (m[f]) touch(f, 1'b0);
                p = 0;
                while (p < NF && m[p]) p++;
                e = (lim - 1) * NF + p + 1;
                if (p == NF) begin p = 0; e = e + NF - NF + NF; e = (lim - 1) * NF + 1 + NF; end
                run_fault(p, e, $sformatf("R11 lim=%0d mask=%0d", lim, m));
            end
        end

        // R2 R6 R7 R8: dirty frame gets extra pass, copy-out then release
        do_reset(1);
        touch(0, 1'b1); touch(1, 1'b0); touch(2, 1'b0); touch(3, 1'b0);
        run_fault(1, 6, "R6 first fault");
        check(wb_req == 1'b1 && wb_frame == 2'd0, "R6 writeback raised for frame 0", int'(wb_frame), 0);
        run_fault(2, 1, "R5 second fault");
        run_fault(3, 1, "R5 third fault");
        run_fault(1, 2, "R7 dirty frame skipped");
        check(wb_req == 1'b1, "R6 request held until ack", int'(wb_req), 1);
        ack_wb();
        check(wb_req == 1'b0, "R6 request drops after ack", int'(wb_req), 0);
        run_fault(2, 1, "R8 fault a");
        run_fault(3, 1, "R8 fault b");
        run_fault(0, 1, "R8 cleaned frame now victim");

        // R8: write during writeback keeps frame dirty
        do_reset(1);
        touch(0, 1'b1); touch(1, 1'b0); touch(2, 1'b0); touch(3, 1'b0);
        run_fault(1, 6, "R8 stale first fault");
        touch(0, 1'b1);
        ack_wb();
        check(wb_req == 1'b0, "R8 stale ack drops request", int'(wb_req), 0);
        run_fault(2, 1, "R8 stale a");
        run_fault(3, 1, "R8 stale b");
        run_fault(1, 2, "R8 stale c");
        run_fault(2, 1, "R8 stale d");
        run_fault(3, 1, "R8 stale e");
        run_fault(1, 2, "R8 still dirty, not chosen");
        check(wb_req == 1'b1 && wb_frame == 2'd0, "R8 new writeback for rewritten frame", int'(wb_req), 1);

        // R4: age saturates at 3 while copy-out pending (clean_lim 2)
        do_reset(2);
        touch(0, 1'b1); touch(1, 1'b1); touch(2, 1'b0); touch(3, 1'b0);
        run_fault(2, 11, "R4 fault 1");
        check(wb_req == 1'b1 && wb_frame == 2'd0, "R6 writeback frame 0 at lim 2", int'(wb_frame), 0);
        run_fault(3, 1, "R4 fault 2");
        run_fault(2, 7, "R4 fault 3");
        ack_wb();
        run_fault(3, 1, "R4 fault 4");
        run_fault(0, 1, "R4 saturated age releases frame");

        // R9: reference meets the hand on frame 0
        do_reset(2);
        fault_req = 1'b1;
        @(negedge clk);
        fault_req = 1'b0;
        repeat (4) @(negedge clk);
        ref_valid = 1'b1; ref_frame = 2'd0; ref_write = 1'b0;
        @(negedge clk);
        ref_valid = 1'b0;
        check(fault_done == 1'b0, "R9 collided frame not chosen", int'(fault_done), 0);
        @(negedge clk);
        check(fault_done == 1'b1 && victim == 2'd1, "R9 next frame chosen", int'(victim), 1);

        // R10: extra request mid-search is ignored
        do_reset(2);
        begin
            int n;
            int extra;
            fault_req = 1'b1;
            @(negedge clk);
            fault_req = 1'b0;
            @(negedge clk);
            fault_req = 1'b1;
            @(negedge clk);
            fault_req = 1'b0;
            n = 3;
            while (!fault_done && n < 100) begin
                @(negedge clk);
                n++;
            end
            check(victim == 2'd0 && n == 6, "R10 search result", n, 6);
            extra = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (fault_done) extra++;
            end
            check(extra == 0, "R10 no second done", extra, 0);
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule